// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block holds the program counter of a simple processor and fetches the instruction at that address. The counter is a byte address. Its upper bits select one word of a small on-block instruction store, and the selected 32-bit word appears on the instruction output without a clock edge in between. The two lowest address bits do not take part in the selection.

At every rising clock edge the counter moves to its next value. Normally this is the following word, four bytes on. When the branch-select and equal-condition inputs are both high, the counter instead moves to a target relative to the following word. The offset for that target comes from the low 16 bits of the word being fetched at that moment. The offset is sign-extended and counts whole words. Comparing register operands, decoding instructions and taking jumps are all done outside the block.

A preload port writes words into the store so that a program can be placed before execution starts, or changed while it runs.

Top module: `ifetch_unit`

## Requirements
- R1: While `rst` is high at a rising edge, the counter becomes 0 at that edge (synchronous reset).
- R2: With `br_sel` and `br_eq` both low, the counter advances by 4 at each edge.
- R3: With `br_sel` and `br_eq` both high, the next counter value is counter + 4 + (sign-extended `instr_o[15:0]` shifted left by 2).
- R4: With exactly one of `br_sel` and `br_eq` high, no branch is taken and the counter advances by 4.
- R5: A negative offset moves the counter backward. An offset field of 0xFFFF leaves the counter unchanged, and 0x8000 moves it back by 131068 bytes.
- R6: `instr_o` is the stored word at index `pc_o[7:2]` for the default 64-word store. Higher counter bits alias onto the same words, and the output follows the counter with no clock of delay.
- R7: Bits [1:0] of `pc_o` are always zero.
- R8: A preload (`ld_en` high) writes `ld_data` to word `ld_addr` at the edge. If that word is being fetched in the same cycle, both the output and the branch offset in that cycle still come from the old contents.
- R9: Counter arithmetic wraps modulo 2^32. A branch from 0 with offset 0xFFFE reaches 0xFFFFFFFC, and the next sequential step returns the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes at its rising edge |
| rst | input | 1 | Synchronous active-high reset of the counter |
| ld_en | input | 1 | Preload write enable |
| ld_addr | input | 6 | Word index for the preload write |
| ld_data | input | 32 | Word written by the preload |
| br_sel | input | 1 | Branch selected by the decoder |
| br_eq | input | 1 | Equality condition from the operand compare |
| pc_o | output | 32 | Current counter (byte address) |
| instr_o | output | 32 | Instruction word at the current counter |

## Verification
The case of interest is a preload that targets the word being fetched, in the same cycle that the block takes a branch using that word's offset. The bench sets the fetched word's offset to 0xFFFF and then overwrites that word while a branch is taken. The counter must stay in place, because the old offset applies. In the following cycle the new word must appear at the same address, and its new offset must steer the next branch. Sweeps over all four select/condition combinations and over the offset extremes are scored against counter values that the bench computes arithmetically.

// File: rtl/ifu_pkg.sv
package ifu_pkg;
   // next-counter source selection
   typedef enum logic {
      NPC_SEQ    = 1'b0,
      NPC_BRANCH = 1'b1
   } npc_src_e;
endpackage

// File: rtl/ifu_pc_reg.sv
module ifu_pc_reg #(
   parameter int unsigned PC_W   = 32,
   parameter logic [PC_W-1:0] RST_PC = '0
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [PC_W-1:0] pc_nxt,
   output logic [PC_W-1:0] pc_q
);
   always_ff @(posedge clk) begin
      if (rst) pc_q <= RST_PC;
      else     pc_q <= pc_nxt;
   end
endmodule

// File: rtl/ifu_next_pc.sv
module ifu_next_pc
   import ifu_pkg::*;
#(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned OFF_W = 16,
   parameter int unsigned SH    = 2
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   input  logic             take,
   output logic [PC_W-1:0]  pc_nxt
);
   localparam int unsigned STEP = 1 << SH;

   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] ext_off;
   logic [PC_W-1:0] tgt_pc;
   npc_src_e        src;

   generate
      if (OFF_W + SH < PC_W) begin : g_sext
         assign ext_off = {{(PC_W-OFF_W-SH){offset[OFF_W-1]}}, offset, {SH{1'b0}}};
      end else begin : g_trunc
         assign ext_off = PC_W'({offset, {SH{1'b0}}});
      end
   endgenerate

   assign seq_pc = pc + PC_W'(STEP);
   assign tgt_pc = seq_pc + ext_off;
   assign src    = take ? NPC_BRANCH : NPC_SEQ;

   always_comb begin
      unique case (src)
         NPC_BRANCH: pc_nxt = tgt_pc;
         default:    pc_nxt = seq_pc;
      endcase
   end
endmodule

// File: rtl/ifu_imem.sv
module ifu_imem #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 64,
   parameter int unsigned IDX_W  = 6
) (
   input  logic              clk,
   input  logic              we,
   input  logic [IDX_W-1:0]  waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  raddr,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   generate
      if (DEPTH == (1 << IDX_W)) begin : g_full
         assign rdata = mem[raddr];
      end else begin : g_partial
         // indices past the last word read as zero
         assign rdata = (raddr < IDX_W'(DEPTH)) ? mem[raddr] : '0;
      end
   endgenerate
endmodule

// File: rtl/ifetch_unit.sv
module ifetch_unit #(
   parameter int unsigned PC_W      = 32,
   parameter int unsigned INSTR_W   = 32,
   parameter int unsigned MEM_WORDS = 64,
   parameter int unsigned OFF_W     = 16,
   parameter logic [PC_W-1:0] RST_PC = '0,
   localparam int unsigned IDX_W = $clog2(MEM_WORDS)
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ld_en,
   input  logic [IDX_W-1:0]   ld_addr,
   input  logic [INSTR_W-1:0] ld_data,
   input  logic               br_sel,
   input  logic               br_eq,
   output logic [PC_W-1:0]    pc_o,
   output logic [INSTR_W-1:0] instr_o
);
   localparam int unsigned SH = $clog2(INSTR_W / 8);

   initial begin
      assert (INSTR_W % 8 == 0 && INSTR_W >= 16) else $error("INSTR_W must be whole bytes, at least 16");
      assert (OFF_W <= INSTR_W) else $error("OFF_W wider than the instruction");
      assert (IDX_W + SH <= PC_W) else $error("store larger than the address space");
      assert (MEM_WORDS >= 2) else $error("MEM_WORDS must be at least 2");
   end

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_nxt;
   logic            take;

   assign take = br_sel & br_eq;

   ifu_pc_reg #(.PC_W(PC_W), .RST_PC(RST_PC)) u_pc (
      .clk    (clk),
      .rst    (rst),
      .pc_nxt (pc_nxt),
      .pc_q   (pc_q)
   );

   ifu_imem #(.DATA_W(INSTR_W), .DEPTH(MEM_WORDS), .IDX_W(IDX_W)) u_mem (
      .clk   (clk),
      .we    (ld_en),
      .waddr (ld_addr),
      .wdata (ld_data),
      .raddr (pc_q[IDX_W+SH-1:SH]),
      .rdata (instr_o)
   );

   ifu_next_pc #(.PC_W(PC_W), .OFF_W(OFF_W), .SH(SH)) u_npc (
      .pc     (pc_q),
      .offset (instr_o[OFF_W-1:0]),
      .take   (take),
      .pc_nxt (pc_nxt)
   );

   assign pc_o = pc_q;
endmodule

// File: rtl/ifetch_unit_chk.sv
module ifetch_unit_chk #(
   parameter int unsigned PC_W    = 32,
   parameter int unsigned INSTR_W = 32,
   parameter int unsigned OFF_W   = 16,
   parameter logic [PC_W-1:0] RST_PC = '0
) (
   input logic               clk,
   input logic               rst,
   input logic               ld_en,
   input logic               br_sel,
   input logic               br_eq,
   input logic [PC_W-1:0]    pc_o,
   input logic [INSTR_W-1:0] instr_o
);
   localparam int unsigned SH = $clog2(INSTR_W / 8);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_W / 8);

   logic [PC_W-1:0] off_bytes;
   assign off_bytes = PC_W'($signed(instr_o[OFF_W-1:0])) << SH;

   AST_PC_RESET: assert property (@(posedge clk) rst |=> pc_o == RST_PC); // R1
   AST_PC_SEQ: assert property (@(posedge clk) disable iff (rst)
      !(br_sel && br_eq) |=> pc_o == $past(pc_o) + STEP); // R2
   AST_PC_BRANCH: assert property (@(posedge clk) disable iff (rst)
      (br_sel && br_eq) |=> pc_o == $past(pc_o) + STEP + $past(off_bytes)); // R3
   AST_PC_ALIGN: assert property (@(posedge clk) disable iff (rst)
      pc_o[SH-1:0] == '0); // R7
   AST_INSTR_HOLD: assert property (@(posedge clk) disable iff (rst)
      ($stable(pc_o) && !$past(ld_en)) |-> $stable(instr_o)); // R6
endmodule

bind ifetch_unit ifetch_unit_chk #(
   .PC_W(PC_W), .INSTR_W(INSTR_W), .OFF_W(OFF_W), .RST_PC(RST_PC)
) u_chk (
   .clk(clk), .rst(rst), .ld_en(ld_en), .br_sel(br_sel), .br_eq(br_eq),
   .pc_o(pc_o), .instr_o(instr_o)
);

// File: tb/tb_ifetch_unit.sv
module tb_ifetch_unit;
   logic        clk = 0;
   logic        rst = 1;
   logic        ld_en = 0;
   logic [5:0]  ld_addr = '0;
   logic [31:0] ld_data = '0;
   logic        br_sel = 0;
   logic        br_eq = 0;
   logic [31:0] pc_o;
   logic [31:0] instr_o;

   int checks = 0;
   int failures = 0;
   logic [31:0] mmem [64];
   logic [31:0] mpc = '0;

   always #5 clk = ~clk;

   ifetch_unit dut (
      .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
      .br_sel(br_sel), .br_eq(br_eq), .pc_o(pc_o), .instr_o(instr_o)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] off_of(input logic [31:0] w);
      return {{14{w[15]}}, w[15:0], 2'b00};
   endfunction

   // one cycle of operation; called just after a falling edge
   task automatic cyc(input logic sel, input logic eq, input logic ld,
                      input logic [5:0] la, input logic [31:0] ld_d, input string req);
      logic [31:0] nxt;
      rst = 0; br_sel = sel; br_eq = eq; ld_en = ld; ld_addr = la; ld_data = ld_d;
      #1;
      chk("R6 fetch", instr_o, mmem[mpc[7:2]]);
      nxt = (sel && eq) ? mpc + 32'd4 + off_of(mmem[mpc[7:2]]) : mpc + 32'd4;
      if (ld) mmem[la] = ld_d;
      @(posedge clk);
      @(negedge clk);
      ld_en = 0;
      mpc = nxt;
      chk(req, pc_o, mpc);
      chk("R7 align", {30'd0, pc_o[1:0]}, 32'd0);
   endtask

   task automatic do_reset(input logic ld, input logic [5:0] la, input logic [31:0] ld_d);
      rst = 1; br_sel = 1; br_eq = 1; ld_en = ld; ld_addr = la; ld_data = ld_d;
      if (ld) mmem[la] = ld_d;
      @(posedge clk);
      @(negedge clk);
      ld_en = 0;
      mpc = '0;
      chk("R1 reset", pc_o, 32'd0);
   endtask

   initial begin
      #2_000_000;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] p;
      @(negedge clk);
      for (int i = 0; i < 64; i++) begin
         logic [15:0] imm;
         imm = 16'(i * 37) - 16'd700;
         do_reset(1'b1, 6'(i), {10'h2A5, 6'(i), imm});
      end
      chk("R6 first word", instr_o, mmem[0]);

      // R2 plain sequential, passing the aliasing point at 256
      for (int i = 0; i < 70; i++) cyc(1'b0, 1'b0, 1'b0, '0, '0, "R2 sequential");
      // R4 one input only
      for (int i = 0; i < 40; i++) cyc(i[0], ~i[0], 1'b0, '0, '0, "R4 half condition");
      // R3 branch sweep mixed with all four combinations
      for (int i = 0; i < 300; i++) cyc(i[0] | i[2], i[1] | i[2], 1'b0, '0, '0, "R3 branch sweep");

      // R5 offset corners at the current word
      foreach (mmem[k]) begin end
      for (int j = 0; j < 5; j++) begin
         logic [15:0] imm;
         case (j)
            0: imm = 16'h0000;
            1: imm = 16'h0001;
            2: imm = 16'h7FFF;
            3: imm = 16'h8000;
            default: imm = 16'hFFFF;
         endcase
         cyc(1'b0, 1'b0, 1'b1, mpc[7:2] + 6'd1, {16'h1234, imm}, "R2 step before corner");
         p = mpc;
         cyc(1'b1, 1'b1, 1'b0, '0, '0, "R5 offset corner");
         chk("R5 corner target", pc_o, p + 32'd4 + {{14{imm[15]}}, imm, 2'b00});
      end
      // backward to the same word
      cyc(1'b0, 1'b0, 1'b1, mpc[7:2] + 6'd1, 32'h5555FFFF, "R2 step");
      p = mpc;
      cyc(1'b1, 1'b1, 1'b0, '0, '0, "R5 self loop");
      chk("R5 offset FFFF holds pc", pc_o, p);

      // R8 preload to fetched word while branching on it
      p = mpc;
      cyc(1'b1, 1'b1, 1'b1, mpc[7:2], 32'hABCD0003, "R8 old offset used");
      chk("R8 pc held by old offset", pc_o, p);
      #1;
      chk("R8 new word visible", instr_o, 32'hABCD0003);
      cyc(1'b1, 1'b1, 1'b0, '0, '0, "R8 new offset used");
      chk("R8 new target", pc_o, p + 32'd16);

      // R9 wrap around the top of the address space
      do_reset(1'b1, 6'd0, 32'h0000FFFE);
      cyc(1'b1, 1'b1, 1'b0, '0, '0, "R9 wrap branch");
      chk("R9 wrap target", pc_o, 32'hFFFFFFFC);
      cyc(1'b0, 1'b0, 1'b0, '0, '0, "R9 wrap step");
      chk("R9 back to zero", pc_o, 32'd0);

      // R1 reset mid-run
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, '0, '0, "R2 sequential");
      do_reset(1'b0, '0, '0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule